// File: doc/BRIEF.md
# Isochronous Resource Manager Lock Registers

This block holds the four shared resource registers that a bus's isochronous resource manager exposes to the other nodes. They are the bus-manager identity, the remaining isochronous bandwidth, and two 32-bit words of free-channel flags. A request supplies a byte offset into a 16-byte register window, a request kind, an extended transaction code, and data and argument operands. One cycle later the block returns a response code and a value. The response code is complete, type error or address error. The value is the old or resulting register contents.

The bus-manager identity uses an ordinary compare-and-swap. The other registers accept the compare-swap code but apply their own rules. The bandwidth register does a bounded allocate or free, and reports success by echoing the argument. A channel word flips only the bits on which argument and data differ, and only when the argument agrees with the register on those bits. Channel 31, which is bit 0 of the high channel word, stays permanently allocated. A 64-bit lock treats both channel words as one value. A bus-reset input reloads every register to its power-up value.

Top module: `irm_lock_regs`

## Requirements
- R1: After `rst_n` is released, and in the cycle after any cycle with `busReset` high, the registers hold these values: identity 0x3F, bandwidth 4915, high channel word 0xFFFFFFFE, low channel word 0xFFFFFFFF. A read (kind 0) of offset 0x00, 0x04, 0x08 or 0x0C returns the matching value with code 0 (complete).
- R2: Each request with `reqValid` high gives `rspValid` high on the following cycle, and no response appears otherwise. The register update completes in that same cycle, so a request issued on the next cycle sees the result of the previous one.
- R3: A write (kind 1) to any of the four registers returns code 6 (type error) and leaves the register unchanged.
- R4: A 32-bit lock (kind 2) or a 64-bit lock (kind 3) whose extended code is not 2 (compare-swap) returns code 6. A 64-bit lock at any offset other than 0x08 also returns code 6. Neither case changes any register.
- R5: An offset whose two low bits are not zero returns code 6. An aligned offset of 0x10 or above returns code 7 (address error).
- R6: A compare-swap on the identity register (offset 0x00) returns the old value. The register takes the data only when the old value equals the argument.
- R7: A bandwidth lock (offset 0x04) with an argument above 0x1FFF returns the old value and changes nothing. Otherwise only the low 13 bits of the data are used.
- R8: When the argument is at least the masked data, the bandwidth lock subtracts (argument − data). It does so only if the result would not go below zero, and returns the argument on success and the old value on failure.
- R9: When the argument is below the masked data, the bandwidth lock adds (data − argument). It does so only if the sum stays below 0x2000, and returns the argument on success and the old value on failure.
- R10: A lock on a channel word (offset 0x08 high, 0x0C low) computes the affected bits as argument XOR data. If the argument and the register agree on every affected bit, the register flips those bits and the lock returns the argument. Otherwise the lock returns the current register and changes nothing.
- R11: Bit 0 of the data is forced to zero before a lock on the high channel word. For a 64-bit lock this is bit 32 of the data. As a result, bit 0 of the high channel word is never set.
- R12: A 64-bit lock at offset 0x08 applies the R10 rule to the 64-bit value {high word, low word} as a whole. It returns either the 64-bit argument or the 64-bit current value on `rspData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busReset | input | 1 | Synchronous reload of power-up register values |
| reqValid | input | 1 | Request present this cycle |
| reqKind | input | 2 | 0 read, 1 write, 2 lock32, 3 lock64 |
| reqAddr | input | ADDR_W | Byte offset into the register window |
| reqExtCode | input | 4 | Extended transaction code (2 = compare-swap) |
| reqData | input | 64 | Data operand (low 32 bits for quadlet requests) |
| reqArg | input | 64 | Argument operand (low 32 bits for quadlet requests) |
| rspValid | output | 1 | Response present |
| rspCode | output | 4 | 0 complete, 6 type error, 7 address error |
| rspData | output | 64 | Returned value (zero on error) |

## Verification
The bench aims at the edges of the bandwidth arithmetic. It covers an argument just past 13 bits, an allocation larger than what remains, a free that would reach 0x2000, and data with bits above bit 12. A design that compared unmasked data, or allowed wrap-around, would return the argument where the old value is due. It also tries to release channel 31 through both the 32-bit and the 64-bit lock, and replays a stale channel argument. A design that did not clear the reserved bit, or did not compare across both words, would set bit 0 or flip bits on the replay. Back-to-back identity swaps expose any result that is not visible to the very next request.

// File: rtl/irm_pkg.sv
package irm_pkg;
  typedef enum logic [1:0] {
    KIND_READ   = 2'd0,
    KIND_WRITE  = 2'd1,
    KIND_LOCK32 = 2'd2,
    KIND_LOCK64 = 2'd3
  } reqKind_e;

  localparam logic [3:0] RC_DONE = 4'h0;
  localparam logic [3:0] RC_TYPE = 4'h6;
  localparam logic [3:0] RC_ADDR = 4'h7;

  localparam logic [1:0] SEL_BM   = 2'd0;
  localparam logic [1:0] SEL_BW   = 2'd1;
  localparam logic [1:0] SEL_CHHI = 2'd2;
  localparam logic [1:0] SEL_CHLO = 2'd3;

  typedef struct packed {
    logic       rd;
    logic       lk32;
    logic       lk64;
    logic [1:0] sel;
  } dpStrobe_t;
endpackage

// File: rtl/irm_ctrl.sv
module irm_ctrl
  import irm_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int CSWAP_CODE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [3:0]        reqExtCode,
  output dpStrobe_t         stb,
  output logic              rspValid,
  output logic [3:0]        rspCode
);
  localparam int WIN_BITS = 4;

  logic       aligned, inWindow, isCswap;
  logic [3:0] codeNext;
  dpStrobe_t  stbNext;

  assign aligned  = (reqAddr[1:0] == 2'b00);
  assign inWindow = (reqAddr[ADDR_W-1:WIN_BITS] == '0);
  assign isCswap  = (reqExtCode == 4'(CSWAP_CODE));

  always_comb begin
    stbNext  = '0;
    codeNext = RC_DONE;
    stbNext.sel = reqAddr[3:2];
    if (!aligned) begin
      codeNext = RC_TYPE;
    end else if (!inWindow) begin
      codeNext = RC_ADDR;
    end else begin
      unique case (reqKind)
        KIND_READ:   stbNext.rd = 1'b1;
        KIND_WRITE:  codeNext = RC_TYPE;
        KIND_LOCK32: begin
          if (isCswap) stbNext.lk32 = 1'b1;
          else         codeNext = RC_TYPE;
        end
        default: begin
          if (isCswap && reqAddr[3:2] == SEL_CHHI) stbNext.lk64 = 1'b1;
          else                                     codeNext = RC_TYPE;
        end
      endcase
    end
    if (!reqValid) begin
      stbNext.rd   = 1'b0;
      stbNext.lk32 = 1'b0;
      stbNext.lk64 = 1'b0;
    end
  end

  assign stb = stbNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspValid <= 1'b0;
      rspCode  <= RC_DONE;
    end else begin
      rspValid <= reqValid;
      rspCode  <= reqValid ? codeNext : RC_DONE;
    end
  end

  // R2: exactly one response per request, one cycle later
  a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> rspValid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !rspValid);
  // R3: writes are refused with a type error
  a_r3_write_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqKind == KIND_WRITE && reqAddr[1:0] == 2'b00 && inWindow)
      |=> rspCode == RC_TYPE);
  // R5: misaligned offsets give a type error
  a_r5_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqAddr[1:0] != 2'b00) |=> rspCode == RC_TYPE);
endmodule

// File: rtl/irm_datapath.sv
module irm_datapath
  import irm_pkg::*;
#(
  parameter int          BW_W       = 13,
  parameter int          BW_DEFAULT = 4915,
  parameter logic [31:0] BM_DEFAULT = 32'h0000_003F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        busReset,
  input  dpStrobe_t   stb,
  input  logic [63:0] reqData,
  input  logic [63:0] reqArg,
  output logic [63:0] rspData
);
  localparam int          QW        = 32;
  localparam logic [31:0] CH_HI_DEF = 32'hFFFF_FFFE;
  localparam logic [31:0] CH_LO_DEF = 32'hFFFF_FFFF;
  localparam logic [31:0] RSV_MASK  = 32'h0000_0001;

  logic [QW-1:0]   bmReg, chHi, chLo;
  logic [BW_W-1:0] bwReg;

  logic [QW-1:0] arg32, data32, dataHiQ;
  assign arg32   = reqArg[QW-1:0];
  assign data32  = reqData[QW-1:0];
  assign dataHiQ = data32 & ~RSV_MASK;

  // Masked toggle rule shared by both channel words and the 64-bit lock
  function automatic logic chAgree(input logic [63:0] r, input logic [63:0] a,
                                   input logic [63:0] d);
    logic [63:0] aff;
    aff = a ^ d;
    return (a & aff) == (r & aff);
  endfunction

  // ---------------- identity ----------------
  logic [QW-1:0] bmNext;
  assign bmNext = (bmReg == arg32) ? data32 : bmReg;

  // ---------------- bandwidth ----------------
  logic            argBig, bwOk;
  logic [BW_W-1:0] argN, dMask, amt, bwNext;
  logic [BW_W:0]   sum;
  logic [QW-1:0]   bwRet;

  assign argBig = |arg32[QW-1:BW_W];
  assign argN   = arg32[BW_W-1:0];
  assign dMask  = data32[BW_W-1:0];

  always_comb begin
    bwOk   = 1'b0;
    bwNext = bwReg;
    amt    = '0;
    sum    = '0;
    if (!argBig) begin
      if (argN >= dMask) begin
        amt = argN - dMask;
        if (bwReg >= amt) begin
          bwOk   = 1'b1;
          bwNext = bwReg - amt;
        end
      end else begin
        amt = dMask - argN;
        sum = {1'b0, bwReg} + {1'b0, amt};
        if (!sum[BW_W]) begin
          bwOk   = 1'b1;
          bwNext = sum[BW_W-1:0];
        end
      end
    end
    bwRet = bwOk ? arg32 : QW'(bwReg);
  end

  // ---------------- channel words, quadlet ----------------
  logic [QW-1:0] chDataQ, chRegQ, chNewQ, chRetQ;
  logic          chOkQ;
  assign chDataQ = (stb.sel == SEL_CHHI) ? dataHiQ : data32;
  assign chRegQ  = (stb.sel == SEL_CHHI) ? chHi : chLo;
  assign chOkQ   = chAgree({32'h0, chRegQ}, {32'h0, arg32}, {32'h0, chDataQ});
  assign chNewQ  = chOkQ ? (chRegQ ^ (arg32 ^ chDataQ)) : chRegQ;
  assign chRetQ  = chOkQ ? arg32 : chRegQ;

  // ---------------- channel words, 64-bit ----------------
  logic [63:0] d64, cur64, new64, ret64;
  logic        ok64;
  assign d64   = {reqData[63:32] & ~RSV_MASK, reqData[31:0]};
  assign cur64 = {chHi, chLo};
  assign ok64  = chAgree(cur64, reqArg, d64);
  assign new64 = ok64 ? (cur64 ^ (reqArg ^ d64)) : cur64;
  assign ret64 = ok64 ? reqArg : cur64;

  // ---------------- read mux ----------------
  logic [QW-1:0] rdVal;
  always_comb begin
    unique case (stb.sel)
      SEL_BM:   rdVal = bmReg;
      SEL_BW:   rdVal = QW'(bwReg);
      SEL_CHHI: rdVal = chHi;
      default:  rdVal = chLo;
    endcase
  end

  logic [QW-1:0] lkRet;
  always_comb begin
    unique case (stb.sel)
      SEL_BM:  lkRet = bmReg;
      SEL_BW:  lkRet = argBig ? QW'(bwReg) : bwRet;
      default: lkRet = chRetQ;
    endcase
  end

  // ---------------- state ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bmReg <= BM_DEFAULT;
      bwReg <= BW_W'(BW_DEFAULT);
      chHi  <= CH_HI_DEF;
      chLo  <= CH_LO_DEF;
    end else if (busReset) begin
      bmReg <= BM_DEFAULT;
      bwReg <= BW_W'(BW_DEFAULT);
      chHi  <= CH_HI_DEF;
      chLo  <= CH_LO_DEF;
    end else if (stb.lk64) begin
      chHi <= new64[63:32];
      chLo <= new64[31:0];
    end else if (stb.lk32) begin
      unique case (stb.sel)
        SEL_BM:   bmReg <= bmNext;
        SEL_BW:   bwReg <= bwNext;
        SEL_CHHI: chHi  <= chNewQ;
        default:  chLo  <= chNewQ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rspData <= '0;
    else if (stb.lk64)   rspData <= ret64;
    else if (stb.lk32)   rspData <= {32'h0, lkRet};
    else if (stb.rd)     rspData <= {32'h0, rdVal};
    else                 rspData <= '0;
  end

  // R1: bus reset reloads power-up values
  a_r1_bus_reset_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    busReset |=> (bmReg == BM_DEFAULT && bwReg == BW_W'(BW_DEFAULT)
                  && chHi == CH_HI_DEF && chLo == CH_LO_DEF));
  // R11: channel 31 never becomes free
  a_r11_ch31_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    !chHi[0]);
  // R7: oversized bandwidth argument leaves the register alone
  a_r7_big_arg_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.lk32 && stb.sel == SEL_BW && argBig && !busReset) |=> $stable(bwReg));
  // R6: identity mismatch keeps the old value
  a_r6_bm_mismatch_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.lk32 && stb.sel == SEL_BM && bmReg != arg32 && !busReset) |=> $stable(bmReg));
  // R4: refused or read-only requests leave the channel words alone
  a_r4_idle_channels_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.lk32 && !stb.lk64 && !busReset) |=> ($stable(chHi) && $stable(chLo)));
endmodule

// File: rtl/irm_lock_regs.sv
module irm_lock_regs
  import irm_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          CSWAP_CODE = 2,
  parameter int          BW_W       = 13,
  parameter int          BW_DEFAULT = 4915,
  parameter logic [31:0] BM_DEFAULT = 32'h0000_003F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busReset,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [3:0]        reqExtCode,
  input  logic [63:0]       reqData,
  input  logic [63:0]       reqArg,
  output logic              rspValid,
  output logic [3:0]        rspCode,
  output logic [63:0]       rspData
);
  dpStrobe_t stb;

  irm_ctrl #(.ADDR_W(ADDR_W), .CSWAP_CODE(CSWAP_CODE)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqValid   (reqValid),
    .reqKind    (reqKind),
    .reqAddr    (reqAddr),
    .reqExtCode (reqExtCode),
    .stb        (stb),
    .rspValid   (rspValid),
    .rspCode    (rspCode)
  );

  irm_datapath #(.BW_W(BW_W), .BW_DEFAULT(BW_DEFAULT), .BM_DEFAULT(BM_DEFAULT)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .busReset (busReset),
    .stb      (stb),
    .reqData  (reqData),
    .reqArg   (reqArg),
    .rspData  (rspData)
  );
endmodule

// File: tb/tb_irm_lock_regs.sv
`timescale 1ns/1ps
module tb_irm_lock_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busReset = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = 2'd0;
  logic [7:0]  reqAddr = 8'h0;
  logic [3:0]  reqExtCode = 4'd2;
  logic [63:0] reqData = '0;
  logic [63:0] reqArg = '0;
  logic        rspValid;
  logic [3:0]  rspCode;
  logic [63:0] rspData;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  irm_lock_regs dut (
    .clk(clk), .rst_n(rst_n), .busReset(busReset), .reqValid(reqValid),
    .reqKind(reqKind), .reqAddr(reqAddr), .reqExtCode(reqExtCode),
    .reqData(reqData), .reqArg(reqArg), .rspValid(rspValid),
    .rspCode(rspCode), .rspData(rspData)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [1:0] k, input logic [7:0] a, input logic [3:0] e,
                       input logic [63:0] d, input logic [63:0] g);
    reqValid = 1'b1; reqKind = k; reqAddr = a; reqExtCode = e; reqData = d; reqArg = g;
  endtask

  // one request; response sampled at the following falling edge
  task automatic xact(input string tag, input logic [1:0] k, input logic [7:0] a,
                      input logic [3:0] e, input logic [63:0] d, input logic [63:0] g,
                      input logic [3:0] expCode, input logic [63:0] expData);
    drive(k, a, e, d, g);
    @(negedge clk);
    reqValid = 1'b0;
    chk({tag, " valid"}, {63'h0, rspValid}, 64'h1);
    chk({tag, " code"}, {60'h0, rspCode}, {60'h0, expCode});
    chk({tag, " data"}, rspData, expData);
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [63:0] exp);
    xact(tag, 2'd0, a, 4'd2, 64'h0, 64'h0, 4'h0, exp);
  endtask

  task automatic tDefaults(input string tag);
    rd({tag, " R1 bm"},   8'h00, 64'h3F);
    rd({tag, " R1 bw"},   8'h04, 64'd4915);
    rd({tag, " R1 chHi"}, 8'h08, 64'hFFFF_FFFE);
    rd({tag, " R1 chLo"}, 8'h0C, 64'hFFFF_FFFF);
  endtask

  task automatic tWrite;
    xact("R3 write bw", 2'd1, 8'h04, 4'd2, 64'h0, 64'h0, 4'h6, 64'h0);
    xact("R3 write chLo", 2'd1, 8'h0C, 4'd2, 64'h0, 64'h0, 4'h6, 64'h0);
    rd("R3 bw unchanged", 8'h04, 64'd4915);
    rd("R3 chLo unchanged", 8'h0C, 64'hFFFF_FFFF);
  endtask

  task automatic tExtCode;
    xact("R4 bad ext", 2'd2, 8'h00, 4'd1, 64'h5, 64'h3F, 4'h6, 64'h0);
    rd("R4 bm unchanged", 8'h00, 64'h3F);
    xact("R4 lock64 wrong offset", 2'd3, 8'h00, 4'd2, 64'h0, 64'h0, 4'h6, 64'h0);
    xact("R4 lock64 bad ext", 2'd3, 8'h08, 4'd3, 64'h0, {32'hFFFF_FFFE, 32'hFFFF_FFFF},
         4'h6, 64'h0);
    rd("R4 chLo unchanged", 8'h0C, 64'hFFFF_FFFF);
  endtask

  task automatic tAddr;
    xact("R5 misaligned read", 2'd0, 8'h05, 4'd2, 64'h0, 64'h0, 4'h6, 64'h0);
    xact("R5 misaligned lock", 2'd2, 8'h02, 4'd2, 64'h0, 64'h0, 4'h6, 64'h0);
    xact("R5 beyond window", 2'd0, 8'h10, 4'd2, 64'h0, 64'h0, 4'h7, 64'h0);
  endtask

  task automatic tBm;
    xact("R6 swap hit", 2'd2, 8'h00, 4'd2, 64'h05, 64'h3F, 4'h0, 64'h3F);
    xact("R6 swap miss", 2'd2, 8'h00, 4'd2, 64'h07, 64'h3F, 4'h0, 64'h05);
    rd("R6 bm value", 8'h00, 64'h05);
  endtask

  task automatic tBw;
    xact("R7 big arg", 2'd2, 8'h04, 4'd2, 64'h0, 64'h2000, 4'h0, 64'd4915);
    rd("R7 bw unchanged", 8'h04, 64'd4915);
    xact("R8 alloc ok", 2'd2, 8'h04, 4'd2, 64'd4815, 64'd4915, 4'h0, 64'd4915);
    rd("R8 bw after alloc", 8'h04, 64'd4815);
    xact("R8 alloc too big", 2'd2, 8'h04, 4'd2, 64'd0, 64'd5000, 4'h0, 64'd4815);
    rd("R8 bw after fail", 8'h04, 64'd4815);
    xact("R9 free ok", 2'd2, 8'h04, 4'd2, 64'd100, 64'd0, 4'h0, 64'd0);
    rd("R9 bw after free", 8'h04, 64'd4915);
    xact("R9 free overflow", 2'd2, 8'h04, 4'd2, 64'h1FFF, 64'd0, 4'h0, 64'd4915);
    rd("R9 bw after overflow", 8'h04, 64'd4915);
    xact("R7 data masked", 2'd2, 8'h04, 4'd2, 64'h2005, 64'd10, 4'h0, 64'd10);
    rd("R7 bw after mask", 8'h04, 64'd4910);
  endtask

  task automatic tCh;
    xact("R10 take lo bit0", 2'd2, 8'h0C, 4'd2, 64'hFFFF_FFFE, 64'hFFFF_FFFF, 4'h0,
         64'hFFFF_FFFF);
    xact("R10 stale retry", 2'd2, 8'h0C, 4'd2, 64'hFFFF_FFFE, 64'hFFFF_FFFF, 4'h0,
         64'hFFFF_FFFE);
    rd("R10 lo value", 8'h0C, 64'hFFFF_FFFE);
    xact("R10 give back", 2'd2, 8'h0C, 4'd2, 64'hFFFF_FFFF, 64'hFFFF_FFFE, 4'h0,
         64'hFFFF_FFFE);
    rd("R10 lo restored", 8'h0C, 64'hFFFF_FFFF);
    xact("R11 release ch31", 2'd2, 8'h08, 4'd2, 64'hFFFF_FFFF, 64'hFFFF_FFFE, 4'h0,
         64'hFFFF_FFFE);
    rd("R11 hi bit0 kept", 8'h08, 64'hFFFF_FFFE);
    xact("R10 take hi bit1", 2'd2, 8'h08, 4'd2, 64'hFFFF_FFFC, 64'hFFFF_FFFE, 4'h0,
         64'hFFFF_FFFE);
    rd("R10 hi value", 8'h08, 64'hFFFF_FFFC);
  endtask

  task automatic tLock64;
    xact("R12 lock64 ok", 2'd3, 8'h08, 4'd2, {32'hFFFF_FFF8, 32'h7FFF_FFFF},
         {32'hFFFF_FFFC, 32'hFFFF_FFFF}, 4'h0, {32'hFFFF_FFFC, 32'hFFFF_FFFF});
    xact("R12 lock64 stale", 2'd3, 8'h08, 4'd2, {32'hFFFF_FFF8, 32'h7FFF_FFFF},
         {32'hFFFF_FFFC, 32'hFFFF_FFFF}, 4'h0, {32'hFFFF_FFF8, 32'h7FFF_FFFF});
    rd("R12 hi after", 8'h08, 64'hFFFF_FFF8);
    rd("R12 lo after", 8'h0C, 64'h7FFF_FFFF);
    xact("R11 lock64 release ch31", 2'd3, 8'h08, 4'd2, {32'hFFFF_FFF9, 32'h7FFF_FFFF},
         {32'hFFFF_FFF8, 32'h7FFF_FFFF}, 4'h0, {32'hFFFF_FFF8, 32'h7FFF_FFFF});
    rd("R11 hi still reserved", 8'h08, 64'hFFFF_FFF8);
  endtask

  task automatic tBackToBack;
    drive(2'd2, 8'h00, 4'd2, 64'h09, 64'h05);
    @(negedge clk);
    chk("R2 first code", {60'h0, rspCode}, 64'h0);
    chk("R2 first data", rspData, 64'h05);
    drive(2'd2, 8'h00, 4'd2, 64'h0A, 64'h09);
    @(negedge clk);
    reqValid = 1'b0;
    chk("R2 second sees first", rspData, 64'h09);
    @(negedge clk);
    chk("R2 idle no response", {63'h0, rspValid}, 64'h0);
    rd("R2 bm final", 8'h00, 64'h0A);
  endtask

  task automatic tBusReset;
    busReset = 1'b1;
    @(negedge clk);
    busReset = 1'b0;
    tDefaults("busReset");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset no response", {63'h0, rspValid}, 64'h0);
    tDefaults("power-up");
    tWrite();
    tExtCode();
    tAddr();
    tBm();
    tBw();
    tCh();
    tLock64();
    tBackToBack();
    tBusReset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule